// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a parallel NOR flash bus interface and the flash's internal operation engine. It watches qualified bus cycles on a shared address/data bus and recognises multi-cycle unlock command sequences. When a sequence completes, it emits a one-cycle request with an operation code and its operand: the address and data of the cycle that completed the sequence. Plain reads are passed through as read requests.

Every multi-cycle command starts with two key writes: AA to address 5555, then 55 to address 2AAA. The third cycle carries a command byte at 5555. A0 arms a word program whose fourth cycle gives the target. 80 arms an erase group that repeats both keys before a final byte selects chip erase, sector erase or boot-block lockout. 90 and F0 enter and leave product-ID mode. A lone F0 write also leaves product-ID mode.

Once lockout has been set, program and sector-erase requests aimed at the boot sector are dropped. A busy input freezes decoding while an operation runs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `req_valid_o`, `id_mode_o` and `boot_locked_o` are 0, and the sequence tracker is idle.
- R2: A cycle with `rd_valid_i`=1, `wr_valid_i`=0 and `busy_i`=0 gives `req_valid_o`=1 with `req_op_o`=1 (read) and `req_addr_o` equal to the cycle's address, on the next clock.
- R3: The writes AA@5555, 55@2AAA, A0@5555, then any address/data give `req_op_o`=2 (program) one clock after the fourth write, with `req_addr_o`/`req_data_o` equal to that fourth write. The earlier writes give no request.
- R4: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, then a sixth write decode as follows. 10@5555 gives `req_op_o`=3 (chip erase). 30 at any address gives 4 (sector erase, with `req_addr_o` the sector address). 40@5555 gives 5 (boot lockout), and `boot_locked_o` is set.
- R5: A third write of 90@5555 after the two keys gives `req_op_o`=6 and sets `id_mode_o`. A third write of F0@5555 gives `req_op_o`=7 and clears it.
- R6: From idle, a single write of F0 to any address gives `req_op_o`=7 and clears `id_mode_o`.
- R7: Matching uses only address bits 15..0 and data bits 7..0. Address bit 16 and data bits 15..8 do not affect decoding.
- R8: A write that is not the expected next cycle returns the tracker to idle with no request. This includes F0 or AA written in the middle of a sequence.
- R9: While `busy_i`=1, writes and reads produce no request on the next clock and do not move the sequence position.
- R10: After lockout, program and sector-erase requests whose address is at most 01FFF (the boot sector) are suppressed. Requests above that address still issue, and the lock holds until reset.
- R11: When `wr_valid_i` and `rd_valid_i` are both 1, the write is decoded and the read is dropped.
- R12: A request lasts one clock; a following cycle with no input gives `req_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Qualified write cycle this clock |
| rd_valid_i | input | 1 | Qualified read cycle this clock |
| busy_i | input | 1 | Operation running; decoding frozen |
| addr_i | input | ADDR_W (17) | Bus word address |
| data_i | input | DATA_W (16) | Bus write data |
| req_valid_o | output | 1 | One-clock request strobe |
| req_op_o | output | 3 | Operation: 0 none, 1 read, 2 program, 3 chip erase, 4 sector erase, 5 boot lockout, 6 ID enter, 7 ID exit |
| req_addr_o | output | ADDR_W | Operand address |
| req_data_o | output | DATA_W | Operand data |
| id_mode_o | output | 1 | Product-ID mode active |
| boot_locked_o | output | 1 | Boot-block lockout set |

## Verification
The bench uses the default parameters: a 17-bit address, a 16-bit data bus, 16 compared address bits and a boot-sector top of 01FFF. The extra address bit and the upper data byte make the don't-care rule observable, because a sequence written at 15555/12AAA with junk in the upper byte must still decode. The boot-sector limit puts program and sector-erase targets on both sides of the lockout boundary (01FFF and 01000 against 02000), so suppression is tested at its edge.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_READ       = 3'd1,
    OP_PROG       = 3'd2,
    OP_CHIP_ERASE = 3'd3,
    OP_SECT_ERASE = 3'd4,
    OP_BOOT_LOCK  = 3'd5,
    OP_ID_ENTER   = 3'd6,
    OP_ID_EXIT    = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_KEY1, S_CMD, S_PROG, S_EKEY0, S_EKEY1, S_ECMD
  } seq_e;

  localparam logic [CMD_W-1:0] KEY_A    = 8'hAA;
  localparam logic [CMD_W-1:0] KEY_B    = 8'h55;
  localparam logic [CMD_W-1:0] CB_PROG  = 8'hA0;
  localparam logic [CMD_W-1:0] CB_EGRP  = 8'h80;
  localparam logic [CMD_W-1:0] CB_IDIN  = 8'h90;
  localparam logic [CMD_W-1:0] CB_IDOUT = 8'hF0;
  localparam logic [CMD_W-1:0] CB_CHIP  = 8'h10;
  localparam logic [CMD_W-1:0] CB_SECT  = 8'h30;
  localparam logic [CMD_W-1:0] CB_LOCK  = 8'h40;
endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match #(
  parameter int                CMP_AW     = 16,
  parameter logic [CMP_AW-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [CMP_AW-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic [CMP_AW-1:0]        addr_i,
  input  logic [fcd_pkg::CMD_W-1:0] cmd_i,
  output logic                     key_a_o,
  output logic                     key_b_o,
  output logic                     at_cmd_o
);
  logic at_a, at_b;
  assign at_a     = (addr_i == KEY_ADDR_A);
  assign at_b     = (addr_i == KEY_ADDR_B);
  assign at_cmd_o = at_a;
  assign key_a_o  = at_a && (cmd_i == fcd_pkg::KEY_A);
  assign key_b_o  = at_b && (cmd_i == fcd_pkg::KEY_B);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             key_a_i,
  input  logic             key_b_i,
  input  logic             at_cmd_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             dec_valid_o,
  output op_e              dec_op_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    dec_valid_o = 1'b0;
    dec_op_o    = OP_NONE;
    if (take_i) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE: begin
          if (key_a_i) state_d = S_KEY1;
          else if (cmd_i == CB_IDOUT) begin
            dec_valid_o = 1'b1;
            dec_op_o    = OP_ID_EXIT;
          end
        end
        S_KEY1:  if (key_b_i) state_d = S_CMD;
        S_CMD: begin
          if (at_cmd_i) begin
            case (cmd_i)
              CB_PROG:  state_d = S_PROG;
              CB_EGRP:  state_d = S_EKEY0;
              CB_IDIN:  begin dec_valid_o = 1'b1; dec_op_o = OP_ID_ENTER; end
              CB_IDOUT: begin dec_valid_o = 1'b1; dec_op_o = OP_ID_EXIT;  end
              default:  state_d = S_IDLE;
            endcase
          end
        end
        S_PROG: begin
          dec_valid_o = 1'b1;
          dec_op_o    = OP_PROG;
        end
        S_EKEY0: if (key_a_i) state_d = S_EKEY1;
        S_EKEY1: if (key_b_i) state_d = S_ECMD;
        S_ECMD: begin
          // sector erase accepts any address; the others need the command address
          if (cmd_i == CB_SECT) begin
            dec_valid_o = 1'b1; dec_op_o = OP_SECT_ERASE;
          end else if (at_cmd_i && cmd_i == CB_CHIP) begin
            dec_valid_o = 1'b1; dec_op_o = OP_CHIP_ERASE;
          end else if (at_cmd_i && cmd_i == CB_LOCK) begin
            dec_valid_o = 1'b1; dec_op_o = OP_BOOT_LOCK;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  // R3: program stage is reached only from the command stage (or held there)
  a_r3_prog_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PROG) |-> ($past(state_q) == S_CMD || $past(state_q) == S_PROG));
  // R8: second erase key only follows the first
  a_r8_erase_keys_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EKEY1) |-> ($past(state_q) == S_EKEY0 || $past(state_q) == S_EKEY1));
endmodule

// File: rtl/fcd_req_gate.sv
module fcd_req_gate
  import fcd_pkg::*;
#(
  parameter int                ADDR_W   = 17,
  parameter int                DATA_W   = 16,
  parameter logic [ADDR_W-1:0] BOOT_TOP = 17'h01FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_take_i,
  input  logic              rd_take_i,
  input  logic              dec_valid_i,
  input  op_e               dec_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_valid_o,
  output op_e               req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              id_mode_o,
  output logic              boot_locked_o
);
  logic boot_hit, blocked, issue_wr, issue_rd;

  assign boot_hit = (addr_i <= BOOT_TOP);
  assign blocked  = boot_locked_o && boot_hit &&
                    (dec_op_i == OP_PROG || dec_op_i == OP_SECT_ERASE);
  assign issue_wr = wr_take_i && dec_valid_i && !blocked;
  assign issue_rd = rd_take_i && !wr_take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o   <= 1'b0;
      req_op_o      <= OP_NONE;
      req_addr_o    <= '0;
      req_data_o    <= '0;
      id_mode_o     <= 1'b0;
      boot_locked_o <= 1'b0;
    end else begin
      req_valid_o <= issue_wr || issue_rd;
      req_op_o    <= issue_wr ? dec_op_i : (issue_rd ? OP_READ : OP_NONE);
      if (issue_wr || issue_rd) begin
        req_addr_o <= addr_i;
        req_data_o <= data_i;
      end
      if (issue_wr && dec_op_i == OP_BOOT_LOCK) boot_locked_o <= 1'b1;
      if (issue_wr && dec_op_i == OP_ID_ENTER)  id_mode_o <= 1'b1;
      if (issue_wr && dec_op_i == OP_ID_EXIT)   id_mode_o <= 1'b0;
    end
  end

  a_r10_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_locked_o |=> boot_locked_o);
  a_r10_no_boot_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && $past(boot_locked_o) &&
     (req_op_o == OP_PROG || req_op_o == OP_SECT_ERASE)) |-> (req_addr_o > BOOT_TOP));
  a_r4_lock_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_op_o == OP_BOOT_LOCK) |-> boot_locked_o);
  a_r5_id_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_op_o == OP_ID_ENTER) |-> id_mode_o);
  a_r6_id_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_op_o == OP_ID_EXIT) |-> !id_mode_o);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int                ADDR_W     = 17,
  parameter int                DATA_W     = 16,
  parameter int                CMP_AW     = 16,
  parameter logic [CMP_AW-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [CMP_AW-1:0] KEY_ADDR_B = 16'h2AAA,
  parameter logic [ADDR_W-1:0] BOOT_TOP   = 17'h01FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              rd_valid_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_valid_o,
  output logic [2:0]        req_op_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              id_mode_o,
  output logic              boot_locked_o
);
  import fcd_pkg::*;

  logic wr_take, rd_take, key_a, key_b, at_cmd, dec_valid;
  op_e  dec_op, op_q;

  assign wr_take  = wr_valid_i && !busy_i;
  assign rd_take  = rd_valid_i && !busy_i;
  assign req_op_o = op_q;

  fcd_cycle_match #(
    .CMP_AW(CMP_AW), .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B)
  ) u_match (
    .addr_i  (addr_i[CMP_AW-1:0]),
    .cmd_i   (data_i[CMD_W-1:0]),
    .key_a_o (key_a),
    .key_b_o (key_b),
    .at_cmd_o(at_cmd)
  );

  fcd_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (wr_take),
    .key_a_i    (key_a),
    .key_b_i    (key_b),
    .at_cmd_i   (at_cmd),
    .cmd_i      (data_i[CMD_W-1:0]),
    .dec_valid_o(dec_valid),
    .dec_op_o   (dec_op)
  );

  fcd_req_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_TOP(BOOT_TOP)
  ) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_take_i    (wr_take),
    .rd_take_i    (rd_take),
    .dec_valid_i  (dec_valid),
    .dec_op_i     (dec_op),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .req_valid_o  (req_valid_o),
    .req_op_o     (op_q),
    .req_addr_o   (req_addr_o),
    .req_data_o   (req_data_o),
    .id_mode_o    (id_mode_o),
    .boot_locked_o(boot_locked_o)
  );

  a_r9_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !req_valid_o);
  a_r11_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && rd_valid_i && !busy_i) |=> (req_op_o != 3'd1));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  typedef struct packed {
    logic        wr;
    logic        rd;
    logic        bsy;
    logic [16:0] addr;
    logic [15:0] data;
    logic        ev;
    logic [2:0]  op;
    logic [3:0]  rq;
  } vec_t;

  function automatic vec_t vx(logic wr, logic rd, logic bsy, logic [16:0] a,
                              logic [15:0] d, logic ev, logic [2:0] op, logic [3:0] rq);
    vec_t v;
    v = '{wr, rd, bsy, a, d, ev, op, rq};
    return v;
  endfunction
  function automatic vec_t vw(logic [16:0] a, logic [15:0] d, logic [3:0] rq);
    return vx(1'b1, 1'b0, 1'b0, a, d, 1'b0, 3'd0, rq);
  endfunction
  function automatic vec_t vq(logic [16:0] a, logic [15:0] d, logic [2:0] op, logic [3:0] rq);
    return vx(1'b1, 1'b0, 1'b0, a, d, 1'b1, op, rq);
  endfunction

  localparam logic [16:0] KA = 17'h05555;
  localparam logic [16:0] KB = 17'h02AAA;
  localparam int N = 80;
  localparam vec_t TBL [N] = '{
    // R3 program
    vw(KA,16'h00AA,3), vw(KB,16'h0055,3), vw(KA,16'h00A0,3), vq(17'h04000,16'h1234,3'd2,3),
    // R2 read, R12 pulse ends
    vx(1'b0,1'b1,1'b0,17'h00100,16'h0000,1'b1,3'd1,2), vx(1'b0,1'b0,1'b0,17'h0,16'h0,1'b0,3'd0,12),
    // R4 chip erase
    vw(KA,16'h00AA,4), vw(KB,16'h0055,4), vw(KA,16'h0080,4), vw(KA,16'h00AA,4), vw(KB,16'h0055,4),
    vq(KA,16'h0010,3'd3,4),
    // R4 sector erase
    vw(KA,16'h00AA,4), vw(KB,16'h0055,4), vw(KA,16'h0080,4), vw(KA,16'h00AA,4), vw(KB,16'h0055,4),
    vq(17'h1F000,16'h0030,3'd4,4),
    // R5 ID entry, read inside ID mode (R2), ID exit
    vw(KA,16'h00AA,5), vw(KB,16'h0055,5), vq(KA,16'h0090,3'd6,5),
    vx(1'b0,1'b1,1'b0,17'h00002,16'h0000,1'b1,3'd1,2),
    vw(KA,16'h00AA,5), vw(KB,16'h0055,5), vq(KA,16'h00F0,3'd7,5),
    // R6 lone exit
    vq(17'h12345,16'h00F0,3'd7,6),
    // R7 upper bits ignored
    vw(17'h15555,16'hFFAA,7), vw(17'h12AAA,16'h3C55,7), vw(17'h15555,16'h00A0,7),
    vq(17'h00010,16'hBEEF,3'd2,7),
    // R8 mismatches
    vw(KA,16'h00AA,8), vw(KA,16'h00AA,8), vw(KB,16'h0055,8), vw(KA,16'h00A0,8),
    vw(17'h04000,16'h0001,8), vw(KA,16'h00AA,8), vw(17'h00000,16'h00F0,8),
    vq(17'h00000,16'h00F0,3'd7,8),
    vw(KA,16'h00AA,8), vw(KB,16'h0055,8), vw(KA,16'h0080,8), vw(KB,16'h0055,8), vw(KA,16'h0010,8),
    // R9 busy holds position
    vw(KA,16'h00AA,9), vx(1'b1,1'b0,1'b1,KB,16'h0055,1'b0,3'd0,9),
    vx(1'b0,1'b1,1'b1,17'h00040,16'h0000,1'b0,3'd0,9),
    vw(KB,16'h0055,9), vw(KA,16'h00A0,9), vq(17'h06000,16'h5555,3'd2,9),
    // R11 write beats read
    vx(1'b1,1'b1,1'b0,17'h00000,16'h00F0,1'b1,3'd7,11),
    vx(1'b1,1'b1,1'b0,KA,16'h00AA,1'b0,3'd0,11),
    vw(KB,16'h0055,11), vw(KA,16'h00A0,11), vq(17'h0ABCD,16'h0F0F,3'd2,11),
    // R4 boot lockout
    vw(KA,16'h00AA,4), vw(KB,16'h0055,4), vw(KA,16'h0080,4), vw(KA,16'h00AA,4), vw(KB,16'h0055,4),
    vq(KA,16'h0040,3'd5,4),
    // R10 boot-sector edge after lock
    vw(KA,16'h00AA,10), vw(KB,16'h0055,10), vw(KA,16'h00A0,10), vw(17'h01FFF,16'h1111,10),
    vw(KA,16'h00AA,10), vw(KB,16'h0055,10), vw(KA,16'h00A0,10), vq(17'h02000,16'h2222,3'd2,10),
    vw(KA,16'h00AA,10), vw(KB,16'h0055,10), vw(KA,16'h0080,10), vw(KA,16'h00AA,10),
    vw(KB,16'h0055,10), vw(17'h01000,16'h0030,10),
    vw(KA,16'h00AA,10), vw(KB,16'h0055,10), vw(KA,16'h0080,10), vw(KA,16'h00AA,10),
    vw(KB,16'h0055,10), vq(17'h02000,16'h0030,3'd4,10)
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0, rd_valid_i = 1'b0, busy_i = 1'b0;
  logic [16:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic        req_valid_o, id_mode_o, boot_locked_o;
  logic [2:0]  req_op_o;
  logic [16:0] req_addr_o;
  logic [15:0] req_data_o;
  int checks = 0, bad = 0;
  logic done = 1'b0;
  logic exp_id = 1'b0, exp_lock = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .rd_valid_i(rd_valid_i),
    .busy_i(busy_i), .addr_i(addr_i), .data_i(data_i), .req_valid_o(req_valid_o),
    .req_op_o(req_op_o), .req_addr_o(req_addr_o), .req_data_o(req_data_o),
    .id_mode_o(id_mode_o), .boot_locked_o(boot_locked_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic wr, logic rd, logic bsy, logic [16:0] a, logic [15:0] d);
    wr_valid_i = wr; rd_valid_i = rd; busy_i = bsy; addr_i = a; data_i = d;
    @(posedge clk);
    @(negedge clk);
    wr_valid_i = 1'b0; rd_valid_i = 1'b0; busy_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(req_valid_o), 0);
    chk("R1 id", 32'(id_mode_o), 0);
    chk("R1 lock", 32'(boot_locked_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      vec_t v;
      string tag;
      v = TBL[i];
      tag = $sformatf("R%0d vec%0d", v.rq, i);
      step(v.wr, v.rd, v.bsy, v.addr, v.data);
      chk({tag, " valid"}, 32'(req_valid_o), 32'(v.ev));
      if (v.ev) begin
        chk({tag, " op"}, 32'(req_op_o), 32'(v.op));
        chk({tag, " addr"}, 32'(req_addr_o), 32'(v.addr));
        if (v.wr) chk({tag, " data"}, 32'(req_data_o), 32'(v.data));
        if (v.op == 3'd5) exp_lock = 1'b1;
        if (v.op == 3'd6) exp_id = 1'b1;
        if (v.op == 3'd7) exp_id = 1'b0;
      end
      chk({tag, " id"}, 32'(id_mode_o), 32'(exp_id));
      chk({tag, " lock"}, 32'(boot_locked_o), 32'(exp_lock));
    end

    // R1: reset mid-sequence clears lock and tracker
    step(1'b1, 1'b0, 1'b0, KA, 16'h00AA);
    step(1'b1, 1'b0, 1'b0, KB, 16'h0055);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 lock after reset", 32'(boot_locked_o), 0);
    chk("R1 valid after reset", 32'(req_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    step(1'b1, 1'b0, 1'b0, KA, 16'h00A0);
    chk("R1 tracker idle", 32'(req_valid_o), 0);
    step(1'b1, 1'b0, 1'b0, 17'h00500, 16'h7777);
    chk("R1 no program after reset", 32'(req_valid_o), 0);
    // R10: boot program allowed again once unlocked by reset
    step(1'b1, 1'b0, 1'b0, KA, 16'h00AA);
    step(1'b1, 1'b0, 1'b0, KB, 16'h0055);
    step(1'b1, 1'b0, 1'b0, KA, 16'h00A0);
    step(1'b1, 1'b0, 1'b0, 17'h00500, 16'h7777);
    chk("R10 boot program unlocked", 32'(req_op_o), 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule